// File: doc/BRIEF.md
# Two-Wire Control Bus Write Master

This block is the master side of a two-wire control bus made of a clock line and a data line. It is used to program small front-end devices such as RF switches. A host asks it for one of two write transactions. A plain register write reaches a 5-bit register space with a single data byte. A masked write reaches an 8-bit register space and sends a mask byte and a data byte. The block assembles the serial frames and appends an odd-parity bit to each one. It then clocks the frames out on the two lines, with a start pattern in front and a park clock behind.

The host presents a request and raises `req_valid` while `busy` is low. All request fields are captured on that clock edge. Every later change on the request inputs has no effect until the transaction is over. The line rate comes from `half_period`: each half of a bus clock period lasts `half_period + 1` system clocks, and the value is latched when the request is accepted. When the transaction finishes, `done` pulses for one clock.

Top module: `ctlbus_master`

## Requirements
- R1: After reset, `bus_clk`, `bus_data`, `busy` and `done` are all 0. They stay that way while no request is accepted.
- R2: The edge that accepts a request starts the start pattern, with `bus_clk` held low throughout. `bus_data` is high for two half-periods and then low for two half-periods.
- R3: Frame bits go out most significant first. The first 12 bits are the 4-bit slave address followed by the command payload. For a register write, that payload is the code 010 followed by `req_addr[4:0]`, and the 12 bits are followed by a parity bit.
- R4: A register write (`req_masked` = 0) has 22 frame bits: the 13-bit command frame, then the data byte and its parity bit.
- R5: A masked write (`req_masked` = 1) has 40 frame bits. The command payload is 00011001 and is followed by a parity bit. Three 9-bit frames come next, in this order: `req_addr`, `req_mask`, `req_data`, each with its own parity bit.
- R6: Each parity bit is 1 exactly when the frame bits before it hold an even number of ones. A data byte of 0x63 gets parity 1, and 0x4C gets parity 0.
- R7: Each bit takes one bus clock period: `bus_clk` is high for one half-period and then low for one. `bus_data` changes only where `bus_clk` rises, so it is stable at every falling edge.
- R8: After the last bit comes the park cycle. `bus_data` is low throughout, and `bus_clk` is high for one half-period and then low for one.
- R9: `busy` is high for exactly (6 + 2·N)·H clocks, where N is the number of frame bits and H is the half-period length. On the clock where `busy` falls, `done` is 1 for that single cycle.
- R10: A request made while `busy` is high is ignored. It does not alter the transaction in flight, and no transaction starts after it.
- R11: A half-period lasts `half_period + 1` system clocks. The value used is the one latched at acceptance, so later changes on the input have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_masked | input | 1 | 0 = register write, 1 = masked write |
| req_sa | input | 4 | Slave address |
| req_addr | input | 8 | Register address (bits 4:0 only for register write) |
| req_mask | input | 8 | Mask byte for masked write |
| req_data | input | 8 | Data byte |
| half_period | input | DIV_W | Half-period length minus one, in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_clk | output | 1 | Serial bus clock |
| bus_data | output | 1 | Serial bus data |

## Verification
Register writes are swept across all 32 short register addresses. The slave address, the data byte and the half-period change with each one, so a swapped or misplaced address bit or code bit shows up as a wrong bit at a known slot. Masked writes use distinct address, mask and data bytes, and some of those bytes have an even number of ones and some an odd number. This separates errors in segment order from errors in the parity sense. The two parity examples and a request made in the middle of a transaction, which also changes the half-period, single out the parity rule and the input latching. The bus waveform is recorded every clock, so busy length, start pattern, bit shape and park cycle are each checked against arithmetic from N and H.

// File: rtl/ctlbus_pkg.sv
`timescale 1ns/1ps
package ctlbus_pkg;
    localparam int SA_W      = 4;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 3;
    localparam int HEAD_W    = SA_W + BYTE_W;
    localparam int CMD_BITS  = HEAD_W + 1;
    localparam int SEG_BITS  = BYTE_W + 1;
    localparam int NUM_SEGS  = 3;
    localparam int RW_BITS   = CMD_BITS + SEG_BITS;
    localparam int MW_BITS   = CMD_BITS + NUM_SEGS * SEG_BITS;
    localparam int FRAME_W   = MW_BITS;
    localparam int NB_W      = $clog2(FRAME_W + 1);
    localparam int SLOT_W    = NB_W + 1;

    localparam logic [CODE_W-1:0] REG_WR_CODE     = 3'b010;
    localparam logic [BYTE_W-1:0] MASK_WR_PAYLOAD = 8'b0001_1001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_PARK  = 2'd3
    } seq_state_e;

    function automatic logic odd_parity(input logic [HEAD_W-1:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/ctlbus_tick.sv
`timescale 1ns/1ps
module ctlbus_tick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == limit);

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: the counter never runs past the latched half-period limit
    a_r11_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= limit));
endmodule

// File: rtl/ctlbus_frame_builder.sv
`timescale 1ns/1ps
module ctlbus_frame_builder
    import ctlbus_pkg::*;
(
    input  logic              masked,
    input  logic [SA_W-1:0]   sa,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] mask,
    input  logic [BYTE_W-1:0] data,
    output logic [FRAME_W-1:0] frame,
    output logic [NB_W-1:0]    nbits
);
    logic [HEAD_W-1:0]   rw_head, mw_head;
    logic [BYTE_W-1:0]   seg_src [NUM_SEGS];
    logic [SEG_BITS-1:0] seg     [NUM_SEGS];

    assign rw_head    = {sa, REG_WR_CODE, addr[BYTE_W-CODE_W-1:0]};
    assign mw_head    = {sa, MASK_WR_PAYLOAD};
    assign seg_src[0] = addr;
    assign seg_src[1] = mask;
    assign seg_src[2] = data;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        assign seg[g] = {seg_src[g], odd_parity({{SA_W{1'b0}}, seg_src[g]})};
    end

    always_comb begin
        if (masked) begin
            frame = {mw_head, odd_parity(mw_head), seg[0], seg[1], seg[2]};
            nbits = NB_W'(MW_BITS);
        end else begin
            frame = {rw_head, odd_parity(rw_head), seg[2],
                     {(FRAME_W-RW_BITS){1'b0}}};
            nbits = NB_W'(RW_BITS);
        end
    end
endmodule

// File: rtl/ctlbus_master.sv
`timescale 1ns/1ps
module ctlbus_master
    import ctlbus_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_masked,
    input  logic [SA_W-1:0]   req_sa,
    input  logic [BYTE_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_mask,
    input  logic [BYTE_W-1:0] req_data,
    input  logic [DIV_W-1:0]  half_period,
    output logic              busy,
    output logic              done,
    output logic              bus_clk,
    output logic              bus_data
);
    typedef struct packed {
        seq_state_e         state;
        logic [SLOT_W-1:0]  slot;
        logic [FRAME_W-1:0] frame;
        logic [NB_W-1:0]    nbits;
        logic [DIV_W-1:0]   half;
        logic               sclk;
        logic               sdata;
        logic               busy;
        logic               done;
    } seq_t;

    seq_t d, q;

    logic [FRAME_W-1:0] bld_frame;
    logic [NB_W-1:0]    bld_nbits;
    logic               tick;
    logic [SLOT_W-1:0]  slot_nx;
    logic [SLOT_W-1:0]  last_bit_slot;
    logic [FRAME_W-1:0] shifted;

    ctlbus_frame_builder u_build (
        .masked (req_masked),
        .sa     (req_sa),
        .addr   (req_addr),
        .mask   (req_mask),
        .data   (req_data),
        .frame  (bld_frame),
        .nbits  (bld_nbits)
    );

    ctlbus_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.state != ST_IDLE),
        .limit (q.half),
        .tick  (tick)
    );

    assign slot_nx       = q.slot + 1'b1;
    assign last_bit_slot = {q.nbits, 1'b0} - 1'b1;
    assign shifted       = {q.frame[FRAME_W-2:0], 1'b0};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state = ST_START;
                    d.slot  = '0;
                    d.frame = bld_frame;
                    d.nbits = bld_nbits;
                    d.half  = half_period;
                    d.sclk  = 1'b0;
                    d.sdata = 1'b1;
                    d.busy  = 1'b1;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.slot == SLOT_W'(3)) begin
                        d.state = ST_BITS;
                        d.slot  = '0;
                        d.sclk  = 1'b1;
                        d.sdata = q.frame[FRAME_W-1];
                    end else begin
                        d.slot  = slot_nx;
                        d.sdata = (slot_nx < SLOT_W'(2));
                    end
                end
            end
            ST_BITS: begin
                if (tick) begin
                    if (q.slot == last_bit_slot) begin
                        d.state = ST_PARK;
                        d.slot  = '0;
                        d.sclk  = 1'b1;
                        d.sdata = 1'b0;
                    end else begin
                        d.slot = slot_nx;
                        d.sclk = ~slot_nx[0];
                        if (!slot_nx[0]) begin
                            d.frame = shifted;
                            d.sdata = shifted[FRAME_W-1];
                        end
                    end
                end
            end
            ST_PARK: begin
                if (tick) begin
                    if (q.slot == '0) begin
                        d.slot  = SLOT_W'(1);
                        d.sclk  = 1'b0;
                        d.sdata = 1'b0;
                    end else begin
                        d.state = ST_IDLE;
                        d.slot  = '0;
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign bus_clk  = q.sclk;
    assign bus_data = q.sdata;

    // R1: an idle bus keeps both lines low
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_clk && !bus_data));
    // R2: a transaction opens with data high and clock low
    a_r2_start_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bus_data && !bus_clk));
    // R7: data holds across every falling clock edge
    a_r7_hold_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_clk) |-> $stable(bus_data));
    // R9: completion pulse coincides with busy falling
    a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9: completion pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a request while busy never restarts the start pattern
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (busy || done));
endmodule

// File: tb/sim_ctlbus_master.sv
`timescale 1ns/1ps
module sim_ctlbus_master;
    localparam int DIV_W = 4;
    localparam int LOG_N = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_masked = 1'b0;
    logic [3:0] req_sa = '0;
    logic [7:0] req_addr = '0, req_mask = '0, req_data = '0;
    logic [DIV_W-1:0] half_period = '0;
    logic busy, done, bus_clk, bus_data;

    always #10 clk = ~clk;

    ctlbus_master #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_masked(req_masked),
        .req_sa(req_sa), .req_addr(req_addr), .req_mask(req_mask),
        .req_data(req_data), .half_period(half_period),
        .busy(busy), .done(done), .bus_clk(bus_clk), .bus_data(bus_data)
    );

    int checks = 0;
    int fails  = 0;
    logic sc_log [LOG_N];
    logic sd_log [LOG_N];
    logic exp_b  [40];
    int   exp_n;
    int   wp;
    int   last_h;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic par_bits(input logic [11:0] v, input int w);
        int ones = 0;
        for (int i = 0; i < w; i++) ones += int'(v[i]);
        return (ones % 2) == 0;
    endfunction

    task automatic push(input logic [11:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) begin
            exp_b[wp] = v[i];
            wp++;
        end
    endtask

    task automatic build_exp(input logic m, input logic [3:0] sa, input logic [7:0] a,
                             input logic [7:0] mk, input logic [7:0] dt);
        logic [11:0] head;
        wp = 0;
        if (!m) begin
            head = {sa, 3'b010, a[4:0]};
            push(head, 12); push({11'b0, par_bits(head, 12)}, 1);
            push({4'b0, dt}, 8); push({11'b0, par_bits({4'b0, dt}, 8)}, 1);
        end else begin
            head = {sa, 8'b0001_1001};
            push(head, 12); push({11'b0, par_bits(head, 12)}, 1);
            push({4'b0, a}, 8);  push({11'b0, par_bits({4'b0, a}, 8)}, 1);
            push({4'b0, mk}, 8); push({11'b0, par_bits({4'b0, mk}, 8)}, 1);
            push({4'b0, dt}, 8); push({11'b0, par_bits({4'b0, dt}, 8)}, 1);
        end
        exp_n = wp;
    endtask

    task automatic run_txn(input logic m, input logic [3:0] sa, input logic [7:0] a,
                           input logic [7:0] mk, input logic [7:0] dt,
                           input int half, input bit poke);
        int len;
        int h;
        int bad_start, bad_bits, bad_shape, bad_park;
        build_exp(m, sa, a, mk, dt);
        h = half + 1;
        last_h = h;
        @(negedge clk);
        req_masked = m; req_sa = sa; req_addr = a; req_mask = mk; req_data = dt;
        half_period = DIV_W'(half); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_sa = ~sa; req_addr = ~a; req_mask = ~mk; req_data = ~dt;
        len = 0;
        while (busy && len < LOG_N) begin
            sc_log[len] = bus_clk;
            sd_log[len] = bus_data;
            if (poke && len == 6) begin
                req_valid = 1'b1;
                half_period = DIV_W'(half + 2);
                req_masked = ~m;
            end else begin
                req_valid = 1'b0;
            end
            len++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R9 / R11: busy length from frame length and latched half-period
        check(len == (6 + 2 * exp_n) * h, "R9 R11 busy length", len, (6 + 2 * exp_n) * h);
        check(done == 1'b1, "R9 done at busy fall", int'(done), 1);
        bad_start = 0; bad_bits = 0; bad_shape = 0; bad_park = 0;
        for (int c = 0; c < 4 * h; c++)
            if (sc_log[c] !== 1'b0 || sd_log[c] !== (c < 2 * h)) bad_start++;
        for (int i = 0; i < exp_n; i++)
            for (int k = 0; k < 2 * h; k++) begin
                if (sd_log[4*h + 2*i*h + k] !== exp_b[i]) bad_bits++;
                if (sc_log[4*h + 2*i*h + k] !== (k < h)) bad_shape++;
            end
        for (int k = 0; k < 2 * h; k++)
            if (sd_log[4*h + 2*exp_n*h + k] !== 1'b0 ||
                sc_log[4*h + 2*exp_n*h + k] !== (k < h)) bad_park++;
        check(bad_start == 0, "R2 start pattern", bad_start, 0);
        if (m) check(bad_bits == 0, "R5 masked frame bits", bad_bits, 0);
        else   check(bad_bits == 0, "R3 R4 register frame bits", bad_bits, 0);
        check(bad_shape == 0, "R7 bit clock shape", bad_shape, 0);
        check(bad_park == 0, "R8 park cycle", bad_park, 0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9 done single cycle", int'(done), 0);
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_clk == 0 && bus_data == 0 && busy == 0 && done == 0,
              "R1 reset outputs", int'({bus_clk, bus_data, busy, done}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(bus_clk == 0 && bus_data == 0 && busy == 0 && done == 0,
              "R1 idle outputs", int'({bus_clk, bus_data, busy, done}), 0);

        // Register write sweep over the whole short address space
        for (int a = 0; a < 32; a++)
            run_txn(1'b0, 4'(a * 7), 8'(a | 8'hE0), 8'h00, 8'(a * 37 + 5), a % 4, 1'b0);

        // Masked write mix of even and odd weight bytes
        for (int i = 0; i < 12; i++)
            run_txn(1'b1, 4'(i + 3), 8'(i * 29 + 1), 8'(8'hA5 ^ i), 8'(i * 53 + 17), i % 4, 1'b0);

        // R6: parity examples in the data frame (bit 21)
        run_txn(1'b0, 4'h6, 8'h01, 8'h00, 8'h63, 0, 1'b0);
        check(sd_log[4*last_h + 2*21*last_h] === 1'b1, "R6 parity of 0x63",
              int'(sd_log[4*last_h + 2*21*last_h]), 1);
        run_txn(1'b0, 4'h7, 8'h1C, 8'h00, 8'h4C, 1, 1'b0);
        check(sd_log[4*last_h + 2*21*last_h] === 1'b0, "R6 parity of 0x4C",
              int'(sd_log[4*last_h + 2*21*last_h]), 0);

        // R10 / R11: request and half-period change while busy are ignored
        for (int p = 0; p < 2; p++) begin
            run_txn(1'(p), 4'h9, 8'h3B, 8'h0F, 8'hC6, 1, 1'b1);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check(busy == 1'b0 && bus_clk == 1'b0, "R10 no late start", int'(busy), 0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule